// File: doc/BRIEF.md
# Byte-Lane Static Memory with Asynchronous-Style Controls

This block models a word-wide static memory behind the control pins a discrete static RAM would have. There are two chip enables of opposite polarity, a write strobe, an output strobe, and one enable per byte lane. All of these are sampled on a single system clock. Per-lane writes, registered reads and high-impedance rules are decoded from those controls. The bidirectional data bus is split into an input word, an output word and one drive-enable per byte lane, so the block contains no tristate buffers. Surrounding logic can join them into a pad if it needs one.

Two status flags go to power-management logic. The standby flag is set whenever the part is deselected or neither lane is enabled. The address-idle flag is set once the address inputs have held still for a parameterised number of clocks, and it drops combinationally as soon as the address moves.

The array is split into a row part (low address bits) and a column part (high address bits). The default configuration is a small array. Setting ROW_BITS=11 and COL_BITS=5 gives the full 2048 x 32 word organisation.

Top module: `byte_sram_if`

## Requirements
- R1: The part is selected only when `chip_en_n` is 0 and `chip_en` is 1. While deselected, no write changes the array and both lane drive-enables are 0 on the next cycle.
- R2: A write happens at the clock edge where the part is selected and `we_n` is 0. Lane 0 (`din[7:0]`) is stored only when `lb_n` is 0, and lane 1 is left unchanged when `ub_n` is 1.
- R3: Lane 1 (`din[15:8]`) is stored only when `ub_n` is 0, and lane 0 is left unchanged when `lb_n` is 1.
- R4: A read is decoded when the part is selected, `oe_n` is 0 and `we_n` is 1. One clock later, `dout` holds the stored word for each enabled lane, and `lane_oe[i]` is 1 exactly for the lanes whose enable is 0 (bit 0 = lower lane via `lb_n`, bit 1 = upper lane via `ub_n`).
- R5: `lane_oe` is 00 on the cycle after a decode in which `oe_n` is 1, or in which both `ub_n` and `lb_n` are 1.
- R6: A write cycle gives `lane_oe` = 00 on the next cycle, whatever the level of `oe_n`.
- R7: One cycle after each decode, `standby` is 1 if the part was deselected or both lane enables were 1, and 0 otherwise.
- R8: After the address changes, `addr_idle` is 0 at first. It becomes 1 after the (IDLE_CYCLES+1)-th clock edge that samples the new, unchanged address (default IDLE_CYCLES = 4).
- R9: `addr_idle` drops to 0 in the same cycle the address input differs from the value sampled at the last edge, before any clock edge.
- R10: Synchronous reset clears `standby`, `addr_idle` and `lane_oe` to 0 and leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Active-low chip enable |
| chip_en | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| ub_n | input | 1 | Active-low upper lane enable |
| lb_n | input | 1 | Active-low lower lane enable |
| addr | input | ROW_BITS+COL_BITS | Word address; low ROW_BITS bits are the row |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data |
| lane_oe | output | 2 | Per-lane drive enable; 0 means high-impedance |
| standby | output | 1 | Registered standby indication |
| addr_idle | output | 1 | Address-idle power-down indication |

## Verification
The assertions assume that every control input is a known 0 or 1 at each clock edge. They also assume that `addr` changes only between edges, so that comparing it with the previously sampled value is meaningful. The bench changes all inputs on the falling edge and always drives each control to a defined level, including during reset. No assertion assumes anything about the array contents, so reads of addresses that were never written cannot trip a property. The bench also writes every word it reads.

// File: rtl/sram_if_pkg.sv
package sram_if_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    MODE_DESEL   = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_OUT_OFF = 2'd3
  } sram_mode_t;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_if_pkg::*;
(
  input  logic             chip_en_n,
  input  logic             chip_en,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output sram_mode_t       mode,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane,
  output logic             standby_d
);

  logic selected;
  logic no_lane;

  assign selected = ~chip_en_n & chip_en;
  assign no_lane  = &be_n;

  always_comb begin
    if (!selected)      mode = MODE_DESEL;
    else if (!we_n)     mode = MODE_WRITE;
    else if (!oe_n)     mode = MODE_READ;
    else                mode = MODE_OUT_OFF;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr_lane[i] = (mode == MODE_WRITE) && !be_n[i];
      rd_lane[i] = (mode == MODE_READ)  && !be_n[i];
    end
  end

  assign standby_d = !selected || no_lane;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              drive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= rd_en;
  end

endmodule

// File: rtl/sram_idle_timer.sv
module sram_idle_timer #(
  parameter int ADDR_W      = 10,
  parameter int IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              idle
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [ADDR_W-1:0] last_addr;
  logic [CNT_W-1:0]  still_cnt;
  logic              moved;

  assign moved = (addr != last_addr);

  always_ff @(posedge clk) begin
    last_addr <= addr;
    if (rst || moved)             still_cnt <= '0;
    else if (still_cnt != CNT_MAX) still_cnt <= still_cnt + 1'b1;
  end

  assign idle = (still_cnt == CNT_MAX) && !moved;

endmodule

// File: rtl/byte_sram_if.sv
module byte_sram_if
  import sram_if_pkg::*;
#(
  parameter int ROW_BITS    = 6,
  parameter int COL_BITS    = 4,
  parameter int IDLE_CYCLES = 4,
  localparam int ADDR_W     = ROW_BITS + COL_BITS,
  localparam int DATA_W     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              chip_en,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  lane_oe,
  output logic              standby,
  output logic              addr_idle
);

  sram_mode_t       mode;
  logic [LANES-1:0] be_n;
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;
  logic             standby_d;
  logic [ADDR_W-1:0] word_addr;

  assign be_n      = {ub_n, lb_n};
  assign word_addr = {addr[ADDR_W-1:ROW_BITS], addr[ROW_BITS-1:0]};

  sram_ctrl_decode u_dec (
    .chip_en_n (chip_en_n),
    .chip_en   (chip_en),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .be_n      (be_n),
    .mode      (mode),
    .wr_lane   (wr_lane),
    .rd_lane   (rd_lane),
    .standby_d (standby_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_array #(
      .ADDR_W (ADDR_W),
      .WIDTH  (LANE_W)
    ) u_arr (
      .clk   (clk),
      .rst   (rst),
      .addr  (word_addr),
      .wr_en (wr_lane[g]),
      .rd_en (rd_lane[g]),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (dout[g*LANE_W +: LANE_W]),
      .drive (lane_oe[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b0;
    else     standby <= standby_d;
  end

  sram_idle_timer #(
    .ADDR_W      (ADDR_W),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_idle (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .idle (addr_idle)
  );

endmodule

// File: rtl/sram_if_checker.sv
module sram_if_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_n,
  input logic              chip_en,
  input logic              we_n,
  input logic              oe_n,
  input logic              ub_n,
  input logic              lb_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        lane_oe,
  input logic              standby,
  input logic              addr_idle
);

  logic sel;
  assign sel = !chip_en_n && chip_en;

  // R1
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (lane_oe == 2'b00));

  // R4
  p_low_lane_drives_r4: assert property (@(posedge clk) disable iff (rst)
    (sel && we_n && !oe_n && !lb_n) |=> lane_oe[0]);

  p_high_lane_drives_r4: assert property (@(posedge clk) disable iff (rst)
    (sel && we_n && !oe_n && !ub_n) |=> lane_oe[1]);

  // R5
  p_oe_off_hiz_r5: assert property (@(posedge clk) disable iff (rst)
    (oe_n || (ub_n && lb_n)) |=> (lane_oe == 2'b00));

  // R6
  p_write_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    (sel && !we_n) |=> (lane_oe == 2'b00));

  // R7
  p_standby_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel || (ub_n && lb_n)) |=> standby);

  p_standby_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && !(ub_n && lb_n)) |=> !standby);

  // R9
  p_idle_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |-> !addr_idle);

  // R10
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!standby && (lane_oe == 2'b00)));

endmodule

bind byte_sram_if sram_if_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chip_en_n (chip_en_n),
  .chip_en   (chip_en),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .ub_n      (ub_n),
  .lb_n      (lb_n),
  .addr      (addr),
  .lane_oe   (lane_oe),
  .standby   (standby),
  .addr_idle (addr_idle)
);

// File: tb/tb_byte_sram_if.sv
`timescale 1ns/1ps
module tb_byte_sram_if;

  localparam int RB = 4;
  localparam int CB = 2;
  localparam int AW = RB + CB;
  localparam int NW = 1 << AW;
  localparam int IDLE = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          chip_en_n, chip_en, we_n, oe_n, ub_n, lb_n;
  logic [AW-1:0] addr;
  logic [15:0]   din;
  logic [15:0]   dout;
  logic [1:0]    lane_oe;
  logic          standby, addr_idle;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NW];

  always #5 clk = ~clk;

  byte_sram_if #(.ROW_BITS(RB), .COL_BITS(CB), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .chip_en(chip_en),
    .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
    .din(din), .dout(dout), .lane_oe(lane_oe), .standby(standby),
    .addr_idle(addr_idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h9E37 + k * 16'h3C1D) ^ 16'h5A5A);
  endfunction

  // drive one cycle of controls at the falling edge, then sample after the rising edge
  task automatic cyc(input logic cn, input logic cp, input logic w, input logic o,
                     input logic u, input logic l, input int a, input logic [15:0] d);
    @(negedge clk);
    chip_en_n = cn; chip_en = cp; we_n = w; oe_n = o; ub_n = u; lb_n = l;
    addr = AW'(a); din = d;
    @(posedge clk); #1;
  endtask

  task automatic read_word(input int a, input string req);
    cyc(0, 1, 1, 0, 0, 0, a, 16'h0);
    chk(req, dout, model[a]);
    chk(req, lane_oe, 2'b11);
  endtask

  initial begin
    rst = 1'b1; chip_en_n = 1; chip_en = 0; we_n = 1; oe_n = 1;
    ub_n = 1; lb_n = 1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 reset standby", standby, 0);
    chk("R10 reset idle", addr_idle, 0);
    chk("R10 reset lane_oe", lane_oe, 0);
    @(negedge clk); rst = 1'b0;

    // R2/R3 full-word fill, R4 readback
    for (int a = 0; a < NW; a++) begin
      model[a] = pat(a, 1);
      cyc(0, 1, 0, 1, 0, 0, a, model[a]);
    end
    for (int a = 0; a < NW; a++) read_word(a, "R4 full read");

    // R2: lower lane only writes
    for (int a = 0; a < NW; a++) begin
      logic [15:0] d = pat(a, 2);
      cyc(0, 1, 0, 0, 1, 0, a, d);
      model[a][7:0] = d[7:0];
    end
    for (int a = 0; a < NW; a++) read_word(a, "R2 lower lane");

    // R3: upper lane only writes on even words
    for (int a = 0; a < NW; a += 2) begin
      logic [15:0] d = pat(a, 3);
      cyc(0, 1, 0, 1, 0, 1, a, d);
      model[a][15:8] = d[15:8];
    end
    for (int a = 0; a < NW; a++) read_word(a, "R3 upper lane");

    // R4: single-lane reads
    cyc(0, 1, 1, 0, 1, 0, 5, 16'h0);
    chk("R4 lower only oe", lane_oe, 2'b01);
    chk("R4 lower only data", dout[7:0], model[5][7:0]);
    cyc(0, 1, 1, 0, 0, 1, 6, 16'h0);
    chk("R4 upper only oe", lane_oe, 2'b10);
    chk("R4 upper only data", dout[15:8], model[6][15:8]);

    // R5: output strobe off, and no lane enabled
    cyc(0, 1, 1, 1, 0, 0, 7, 16'h0);
    chk("R5 oe_n high", lane_oe, 2'b00);
    cyc(0, 1, 1, 0, 1, 1, 7, 16'h0);
    chk("R5 no lane", lane_oe, 2'b00);

    // R6: write with oe_n low still high-impedance
    model[9] = 16'hC3A5;
    cyc(0, 1, 0, 0, 0, 0, 9, model[9]);
    chk("R6 write hiz", lane_oe, 2'b00);
    read_word(9, "R6 write stored");

    // R1: deselected by each chip-enable combination, writes ignored
    for (int c = 0; c < 4; c++) begin
      logic cn = c[0];
      logic cp = c[1];
      if (!cn && cp) continue;
      cyc(cn, cp, 0, 0, 0, 0, 11, 16'hFFFF ^ model[11]);
      chk("R1 desel write hiz", lane_oe, 2'b00);
      cyc(cn, cp, 1, 0, 0, 0, 11, 16'h0);
      chk("R1 desel read hiz", lane_oe, 2'b00);
    end
    read_word(11, "R1 desel write ignored");

    // R7: standby sweep across chip enables and lane enables
    for (int c = 0; c < 16; c++) begin
      logic cn = c[0];
      logic cp = c[1];
      logic u = c[2];
      logic l = c[3];
      cyc(cn, cp, 1, 1, u, l, 12, 16'h0);
      chk("R7 standby", standby, (!(!cn && cp) || (u && l)) ? 1 : 0);
    end

    // R8/R9: idle flag timing
    cyc(1, 0, 1, 1, 1, 1, 20, 16'h0);
    repeat (8) begin @(posedge clk); end
    #1;
    chk("R8 idle long hold", addr_idle, 1);
    @(negedge clk); addr = AW'(21); #1;
    chk("R9 idle drops same cycle", addr_idle, 0);
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk); #1;
      chk("R8 idle count", addr_idle, (k > IDLE) ? 1 : 0);
    end

    // R10: reset keeps array contents, clears flags
    @(negedge clk); rst = 1'b1; chip_en_n = 1; chip_en = 0;
    @(posedge clk); #1;
    chk("R10 reset standby", standby, 0);
    chk("R10 reset idle", addr_idle, 0);
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < NW; a += 7) read_word(a, "R10 contents kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule